// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Decoder

This block is the front end of a NAND flash device. It sits on the asynchronous host bus, where one 8-bit I/O bus carries commands, addresses and data bytes in turn. A fast system clock samples every strobe. These are the chip-enables, write-enable, read-enable, the command and address latch enables, and write-protect. Each one passes through a two-stage synchronizer. The block then decides from the strobe levels alone what each write-enable rising edge means:

- a command byte, which goes into a command register;
- an address byte, which is shifted into an address register and counted;
- a data-in byte.

A falling read-enable asks for the next data-out byte.

There is one decode lane per chip-enable, and each lane serves its own array. Each lane has a busy input from its array. While busy is high, the lane accepts only the two status-read opcodes and the reset opcode. The lane also reports standby whenever its chip-enable is high and it is not busy. The host bus is the master and cannot be stalled. For that reason, every event leaves the block as a one-cycle valid pulse, with no ready signal. The array side must take each pulse in the cycle it appears.

Top module: `nand_bus_front`

## Requirements
- R1: After reset, all event pulses are 0. Every cmd_code, addr_value and addr_count is 0, every standby bit is 1 and write_locked is 0.
- R2: A write-enable rise is a command cycle when the lane's chip-enable is low, command-latch is high and address-latch is low. If the lane is not busy, cmd_code takes the byte and cmd_valid pulses for one cycle, 3 clock edges after the rise reaches the pins.
- R3: While the lane's busy is high, only opcodes 8'h70, 8'h78 and 8'hFF are accepted as in R2. Any other command byte gives no pulse and leaves cmd_code unchanged.
- R4: An address cycle has chip-enable low, command-latch low and address-latch high. The byte enters addr_value from the top, as {byte, addr_value[39:8]}, addr_count rises by one and addr_valid pulses. Once addr_count is 5, further address bytes give no pulse and change nothing.
- R5: An accepted command sets addr_count and addr_value to 0.
- R6: Only the lowest 36 bits of the 40-bit address exist. The k-th address byte (k = addr_count before it) raises addr_fault, together with addr_valid, if any bit at position 8k+i >= 36 is set. The byte is still latched.
- R7: A write-enable rise with both latch enables high changes nothing and gives no pulse.
- R8: A write-enable rise with chip-enable low and both latch enables low pulses din_valid, with the byte on din_data.
- R9: A read-enable fall with chip-enable low and both latch enables low pulses dout_req.
- R10: A lane whose chip-enable is high reacts to no strobe. Its standby bit is 1 exactly when its synchronized chip-enable is high and busy is low, including when chip-enable rises right after a data transfer.
- R11: Each chip-enable drives only its own lane. A cycle for lane 0 leaves every output of lane 1 unchanged, and the reverse.
- R12: write_locked equals the inverse of wp_n, 2 clock edges late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | N_CE | Chip-enables, active low, one per lane |
| we_n | input | 1 | Write-enable strobe, rising edge latches |
| re_n | input | 1 | Read-enable strobe, falling edge requests data |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write-protect, active low |
| io_in | input | 8 | Shared I/O byte bus |
| busy | input | N_CE | Busy from each array, synchronous to clk |
| cmd_valid | output | N_CE | One-cycle pulse per accepted command |
| cmd_code | output | N_CE*8 | Latched command per lane |
| addr_valid | output | N_CE | One-cycle pulse per latched address byte |
| addr_value | output | N_CE*ADDR_CYCLES*8 | Shifting address register per lane |
| addr_count | output | N_CE*CNT_W | Address bytes since the last command |
| addr_fault | output | N_CE | Pulse: address byte set an unused bit |
| din_valid | output | N_CE | One-cycle pulse per data-in byte |
| din_data | output | 8 | Byte of the latest write-enable rise |
| dout_req | output | N_CE | One-cycle pulse requesting a data-out byte |
| standby | output | N_CE | Lane is deselected and idle |
| write_locked | output | 1 | Synchronized write-protect |

## Verification
The checker watches every cycle for the following:
- an opcode accepted while busy that is not one of the three exempt ones;
- address counts beyond five or counts that do not step by one;
- a command that leaves the count non-zero;
- faults without an address pulse;
- two event kinds in one cycle;
- events while in standby;
- pulses longer than one cycle.

Only the bench's scenarios can show the rest: exact latched values and their latency, the contents of the shifted address, the ignored sixth byte, and the ignored invalid and deselected cycles. The same holds for the independence of the two lanes and the standby rise after a transfer.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;
  localparam int WORD_W = 8;
  localparam logic [WORD_W-1:0] OP_STATUS    = 8'h70;
  localparam logic [WORD_W-1:0] OP_STATUS_MD = 8'h78;
  localparam logic [WORD_W-1:0] OP_RESET     = 8'hFF;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_CMD,
    CYC_ADDR,
    CYC_DATA,
    CYC_BAD
  } cycle_e;

  // Decide the meaning of a strobe edge from the latch-enable levels.
  function automatic cycle_e classify(input logic sel, input logic cle, input logic ale);
    if (!sel)            return CYC_NONE;
    else if (cle && ale) return CYC_BAD;
    else if (cle)        return CYC_CMD;
    else if (ale)        return CYC_ADDR;
    else                 return CYC_DATA;
  endfunction

  function automatic logic busy_exempt(input logic [WORD_W-1:0] op);
    return (op == OP_STATUS) || (op == OP_STATUS_MD) || (op == OP_RESET);
  endfunction
endpackage

// File: rtl/nand_sync.sv
module nand_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/nand_edge.sv
module nand_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/nand_lane.sv
module nand_lane
  import nand_front_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int ADDR_BITS   = 36,
  localparam int ADDR_W = ADDR_CYCLES * WORD_W,
  localparam int CNT_W  = $clog2(ADDR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              busy,
  input  logic              cle_s,
  input  logic              ale_s,
  input  logic              we_rise,
  input  logic              re_fall,
  input  logic [WORD_W-1:0] io_s,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_code,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_value,
  output logic [CNT_W-1:0]  addr_count,
  output logic              addr_fault,
  output logic              din_valid,
  output logic              dout_req,
  output logic              standby
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ADDR_CYCLES);

  cycle_e            cyc;
  logic              cmd_take;
  logic              addr_take;
  logic [ADDR_W-1:0] addr_next;
  logic [WORD_W-1:0] live_mask;

  function automatic logic [WORD_W-1:0] used_mask(input logic [CNT_W-1:0] k);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = ((int'(k) * WORD_W + i) < ADDR_BITS);
    return m;
  endfunction

  assign cyc       = classify(~ce_n_s, cle_s, ale_s);
  assign cmd_take  = we_rise && (cyc == CYC_CMD) && (!busy || busy_exempt(io_s));
  assign addr_take = we_rise && (cyc == CYC_ADDR) && (addr_count < CNT_MAX);
  assign live_mask = used_mask(addr_count);

  if (ADDR_CYCLES == 1) begin : g_one
    assign addr_next = io_s;
  end else begin : g_shift
    assign addr_next = {io_s, addr_value[ADDR_W-1:WORD_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_code   <= '0;
      addr_valid <= 1'b0;
      addr_value <= '0;
      addr_count <= '0;
      addr_fault <= 1'b0;
      din_valid  <= 1'b0;
      dout_req   <= 1'b0;
      standby    <= 1'b1;
    end else begin
      cmd_valid  <= cmd_take;
      addr_valid <= addr_take;
      addr_fault <= addr_take && |(io_s & ~live_mask);
      din_valid  <= we_rise && (cyc == CYC_DATA);
      dout_req   <= re_fall && (cyc == CYC_DATA);
      standby    <= ce_n_s && !busy;
      if (cmd_take) begin
        cmd_code   <= io_s;
        addr_value <= '0;
        addr_count <= '0;
      end else if (addr_take) begin
        addr_value <= addr_next;
        addr_count <= addr_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nand_front_pkg::*;
#(
  parameter int N_CE        = 2,
  parameter int ADDR_CYCLES = 5,
  parameter int ADDR_BITS   = 36,
  localparam int ADDR_W = ADDR_CYCLES * WORD_W,
  localparam int CNT_W  = $clog2(ADDR_CYCLES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CE-1:0]          ce_n,
  input  logic                     we_n,
  input  logic                     re_n,
  input  logic                     cle,
  input  logic                     ale,
  input  logic                     wp_n,
  input  logic [WORD_W-1:0]        io_in,
  input  logic [N_CE-1:0]          busy,
  output logic [N_CE-1:0]          cmd_valid,
  output logic [N_CE*WORD_W-1:0]   cmd_code,
  output logic [N_CE-1:0]          addr_valid,
  output logic [N_CE*ADDR_W-1:0]   addr_value,
  output logic [N_CE*CNT_W-1:0]    addr_count,
  output logic [N_CE-1:0]          addr_fault,
  output logic [N_CE-1:0]          din_valid,
  output logic [WORD_W-1:0]        din_data,
  output logic [N_CE-1:0]          dout_req,
  output logic [N_CE-1:0]          standby,
  output logic                     write_locked
);
  localparam int CTL_W = N_CE + 5;
  localparam logic [CTL_W-1:0] CTL_RST = {{N_CE{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic [CTL_W-1:0]  ctl_s;
  logic [N_CE-1:0]   ce_n_s;
  logic              we_s, re_s, cle_s, ale_s, wp_s;
  logic [WORD_W-1:0] io_s;
  logic [1:0]        rise, fall;
  logic              we_rise, re_fall;

  nand_sync #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, we_n, re_n, cle, ale, wp_n}),
    .q(ctl_s)
  );

  nand_sync #(.W(WORD_W), .RST_VAL('0)) u_io_sync (
    .clk(clk), .rst_n(rst_n), .d(io_in), .q(io_s)
  );

  assign {ce_n_s, we_s, re_s, cle_s, ale_s, wp_s} = ctl_s;

  nand_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({we_s, re_s}), .rise(rise), .fall(fall)
  );

  assign we_rise      = rise[1];
  assign re_fall      = fall[0];
  assign write_locked = ~wp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       din_data <= '0;
    else if (we_rise) din_data <= io_s;
  end

  for (genvar g = 0; g < N_CE; g++) begin : g_lane
    nand_lane #(.ADDR_CYCLES(ADDR_CYCLES), .ADDR_BITS(ADDR_BITS)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .ce_n_s(ce_n_s[g]), .busy(busy[g]),
      .cle_s(cle_s), .ale_s(ale_s),
      .we_rise(we_rise), .re_fall(re_fall), .io_s(io_s),
      .cmd_valid(cmd_valid[g]),
      .cmd_code(cmd_code[g*WORD_W +: WORD_W]),
      .addr_valid(addr_valid[g]),
      .addr_value(addr_value[g*ADDR_W +: ADDR_W]),
      .addr_count(addr_count[g*CNT_W +: CNT_W]),
      .addr_fault(addr_fault[g]),
      .din_valid(din_valid[g]),
      .dout_req(dout_req[g]),
      .standby(standby[g])
    );
  end
endmodule

// File: rtl/nand_front_chk.sv
module nand_front_chk
  import nand_front_pkg::*;
#(
  parameter int N_CE        = 2,
  parameter int ADDR_CYCLES = 5,
  localparam int ADDR_W = ADDR_CYCLES * WORD_W,
  localparam int CNT_W  = $clog2(ADDR_CYCLES + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CE-1:0]        busy,
  input logic [N_CE-1:0]        cmd_valid,
  input logic [N_CE*WORD_W-1:0] cmd_code,
  input logic [N_CE-1:0]        addr_valid,
  input logic [N_CE*ADDR_W-1:0] addr_value,
  input logic [N_CE*CNT_W-1:0]  addr_count,
  input logic [N_CE-1:0]        addr_fault,
  input logic [N_CE-1:0]        din_valid,
  input logic [N_CE-1:0]        dout_req,
  input logic [N_CE-1:0]        standby
);
  for (genvar g = 0; g < N_CE; g++) begin : g_chk
    logic [WORD_W-1:0] code;
    logic [CNT_W-1:0]  cnt;
    assign code = cmd_code[g*WORD_W +: WORD_W];
    assign cnt  = addr_count[g*CNT_W +: CNT_W];

    // R3
    busy_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid[g] && $past(busy[g]) |-> busy_exempt(code));
    // R4
    addr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) <= ADDR_CYCLES);
    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid[g] |-> cnt == $past(cnt) + 1'b1);
    // R5
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid[g] |-> cnt == '0);
    // R6
    fault_with_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_fault[g] |-> addr_valid[g]);
    // R7
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid[g], addr_valid[g], din_valid[g]}));
    // R10
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby[g] |-> !(cmd_valid[g] || addr_valid[g] || din_valid[g] || dout_req[g]));
    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid[g] |=> !cmd_valid[g]);
  end
endmodule

bind nand_bus_front nand_front_chk #(.N_CE(N_CE), .ADDR_CYCLES(ADDR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .addr_valid(addr_valid), .addr_value(addr_value), .addr_count(addr_count),
  .addr_fault(addr_fault), .din_valid(din_valid), .dout_req(dout_req),
  .standby(standby)
);

// File: tb/sim_nand_bus_front.sv
module sim_nand_bus_front;
  localparam int NC = 2;
  localparam int AC = 5;
  localparam int AB = 36;
  localparam int AW = AC * 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] ce_n = '1;
  logic we_n = 1'b1, re_n = 1'b1, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic [7:0] io_in = '0;
  logic [NC-1:0] busy = '0;
  logic [NC-1:0] cmd_valid, addr_valid, addr_fault, din_valid, dout_req, standby;
  logic [NC*8-1:0] cmd_code;
  logic [NC*AW-1:0] addr_value;
  logic [NC*CW-1:0] addr_count;
  logic [7:0] din_data;
  logic write_locked;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]    e_cmd [NC];
  logic [AW-1:0] e_addr[NC];
  int            e_cnt [NC];

  always #10 clk = ~clk;

  nand_bus_front #(.N_CE(NC), .ADDR_CYCLES(AC), .ADDR_BITS(AB)) u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exempt(input logic [7:0] b);
    return b == 8'h70 || b == 8'h78 || b == 8'hFF;
  endfunction

  function automatic bit fault_of(input int k, input logic [7:0] b);
    for (int i = 0; i < 8; i++) if (k * 8 + i >= AB && b[i]) return 1;
    return 0;
  endfunction

  task automatic lane_state(input int ln, input string tag);
    check({tag, " cmd_code"}, 64'(cmd_code[ln*8 +: 8]), 64'(e_cmd[ln]));
    check({tag, " addr_value"}, 64'(addr_value[ln*AW +: AW]), 64'(e_addr[ln]));
    check({tag, " addr_count"}, 64'(addr_count[ln*CW +: CW]), 64'(e_cnt[ln]));
  endtask

  // One write-enable cycle; nosel keeps every chip-enable high.
  task automatic bus_wr(input int ln, input bit c, input bit a, input logic [7:0] b,
                        input bit bsy, input bit nosel);
    bit ec = 0, ea = 0, ef = 0, ed = 0;
    int o = 1 - ln;
    if (!nosel) begin
      if (c && !a) begin
        if (!bsy || exempt(b)) begin
          ec = 1; e_cmd[ln] = b; e_addr[ln] = '0; e_cnt[ln] = 0;
        end
      end else if (a && !c) begin
        if (e_cnt[ln] < AC) begin
          ea = 1; ef = fault_of(e_cnt[ln], b);
          e_addr[ln] = {b, e_addr[ln][AW-1:8]}; e_cnt[ln]++;
        end
      end else if (!a && !c) ed = 1;
    end
    @(negedge clk);
    ce_n <= nosel ? '1 : ~(NC'(1) << ln);
    cle <= c; ale <= a; io_in <= b;
    busy <= bsy ? (NC'(1) << ln) : '0;
    we_n <= 1'b0;
    repeat (3) @(negedge clk);
    we_n <= 1'b1;
    repeat (3) @(negedge clk);
    check("R2 R3 cmd_valid", 64'(cmd_valid[ln]), 64'(ec));
    check("R4 addr_valid", 64'(addr_valid[ln]), 64'(ea));
    check("R6 addr_fault", 64'(addr_fault[ln]), 64'(ef));
    check("R8 din_valid", 64'(din_valid[ln]), 64'(ed));
    if (ed) check("R8 din_data", 64'(din_data), 64'(b));
    check("R10 standby", 64'(standby[ln]), 64'(nosel && !bsy));
    check("R11 other lane quiet", 64'({cmd_valid[o], addr_valid[o], din_valid[o]}), 64'(0));
    lane_state(ln, "R4 R5 R7");
    lane_state(o, "R11");
    @(negedge clk);
    ce_n <= '1; cle <= 1'b0; ale <= 1'b0; busy <= '0;
  endtask

  task automatic bus_rd(input int ln);
    @(negedge clk);
    ce_n <= ~(NC'(1) << ln); cle <= 1'b0; ale <= 1'b0;
    repeat (3) @(negedge clk);
    re_n <= 1'b0;
    repeat (3) @(negedge clk);
    check("R9 dout_req", 64'(dout_req[ln]), 64'(1));
    check("R11 other dout_req", 64'(dout_req[1-ln]), 64'(0));
    re_n <= 1'b1;
    repeat (2) @(negedge clk);
    ce_n <= '1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NC; i++) begin e_cmd[i] = '0; e_addr[i] = '0; e_cnt[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n <= 1'b1;
    repeat (2) @(negedge clk);
    // R1
    check("R1 pulses", 64'({cmd_valid, addr_valid, addr_fault, din_valid, dout_req}), 64'(0));
    check("R1 standby", 64'(standby), 64'(2'b11));
    check("R1 write_locked", 64'(write_locked), 64'(0));
    lane_state(0, "R1"); lane_state(1, "R1");
    // R12
    wp_n <= 1'b0;
    @(negedge clk);
    check("R12 early", 64'(write_locked), 64'(0));
    @(negedge clk);
    check("R12 locked", 64'(write_locked), 64'(1));
    wp_n <= 1'b1;
    repeat (2) @(negedge clk);
    check("R12 released", 64'(write_locked), 64'(0));
    // R2 and R4: command, five address bytes, a sixth ignored
    bus_wr(0, 1, 0, 8'h00, 0, 0);
    bus_wr(0, 0, 1, 8'h11, 0, 0);
    bus_wr(0, 0, 1, 8'h22, 0, 0);
    bus_wr(0, 0, 1, 8'h33, 0, 0);
    bus_wr(0, 0, 1, 8'h44, 0, 0);
    bus_wr(0, 0, 1, 8'h0F, 0, 0);
    check("R4 full address", 64'(addr_value[AW-1:0]), 64'(40'h0F_4433_2211));
    bus_wr(0, 0, 1, 8'hAA, 0, 0);
    // R5
    bus_wr(0, 1, 0, 8'h30, 0, 0);
    // R6: unused bits of the last byte
    for (int i = 0; i < 4; i++) bus_wr(0, 0, 1, 8'hFF, 0, 0);
    bus_wr(0, 0, 1, 8'hF3, 0, 0);
    // R3: busy gating
    bus_wr(0, 1, 0, 8'h80, 1, 0);
    bus_wr(0, 1, 0, 8'h70, 1, 0);
    bus_wr(0, 1, 0, 8'h78, 1, 0);
    bus_wr(0, 1, 0, 8'h05, 1, 0);
    bus_wr(0, 1, 0, 8'hFF, 1, 0);
    // R7
    bus_wr(0, 1, 1, 8'h5A, 0, 0);
    // R8, R9 and R10 after a transfer
    bus_wr(0, 0, 0, 8'hC3, 0, 0);
    repeat (3) @(negedge clk);
    check("R10 standby after transfer", 64'(standby[0]), 64'(1));
    bus_rd(0);
    // R10: deselected cycles and busy standby
    bus_wr(0, 1, 0, 8'h90, 0, 1);
    bus_wr(0, 0, 1, 8'h90, 1, 1);
    // R11: lane 1
    bus_wr(1, 1, 0, 8'h60, 0, 0);
    bus_wr(1, 0, 1, 8'h12, 0, 0);
    bus_rd(1);
    // random traffic
    for (int n = 0; n < 250; n++) begin
      int k = $urandom_range(0, 6);
      int ln = $urandom_range(0, 1);
      bit bz = ($urandom_range(0, 3) == 0);
      logic [7:0] b = 8'($urandom_range(0, 255));
      case (k)
        0: bus_wr(ln, 1, 0, ($urandom_range(0, 2) == 0) ? 8'h70 : b, bz, 0);
        1, 2: bus_wr(ln, 0, 1, b, bz, 0);
        3: bus_wr(ln, 0, 0, b, bz, 0);
        4: bus_rd(ln);
        5: bus_wr(ln, 1, 1, b, bz, 0);
        default: bus_wr(ln, 1, 0, b, bz, 1);
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule